// File: doc/BRIEF.md
# Segment Selector Translation Unit

This block converts a segment selector and a 32-bit effective address into a 32-bit linear address. It uses the protected-mode scheme: each selector refers to an 8-byte descriptor, and the descriptor lives in either a global table or a local table. The block holds four pieces of state:

- a 48-bit global table register;
- a cached base and limit for the current local table;
- a cached base and expanded limit for one active segment;
- a `valid` flag for that active segment.

Loading a selector starts a descriptor fetch. The fetch uses a 32-bit read port with a valid/ready handshake.

A local table is reached in two levels. First, loading the local-table selector fetches a global descriptor, which fills the local base/limit cache. After that, any segment selector with its table bit set is resolved through that cache.

Each translation is a combinational add of the cached base and the effective address. A limit compare runs beside the add and raises a fault when the offset is out of range.

The fetch controller has six named states:

| State | Role | Transitions |
|---|---|---|
| `ST_IDLE` | Waits for a load. | Goes to `ST_CHECK` when a load is accepted. |
| `ST_CHECK` | Decodes the latched selector and checks it against the chosen table's bound. | Goes to `ST_COMMIT` for a null selector, `ST_FAULT` for a bound error, and `ST_RD_LO` otherwise. |
| `ST_RD_LO` | Reads the low descriptor word. | Goes to `ST_RD_HI` when `rd_ready` is high. |
| `ST_RD_HI` | Reads the high descriptor word. | Goes to `ST_COMMIT` when `rd_ready` is high. |
| `ST_COMMIT` | Writes the target cache. | Returns to `ST_IDLE`. |
| `ST_FAULT` | Reports the error and leaves both caches as they were. | Returns to `ST_IDLE`. |

Top module: `seg_xlate`

## Requirements
- R1: A selector is decoded as follows. Bits 15:3 are the table index. Bit 2 picks the table: 0 is the global table and 1 is the local table. Bits 1:0 are the requested privilege level and have no effect on translation.
- R2: A descriptor fetch makes two reads. The first is at table base + index*8 and the second is at that address + 4. While `rd_valid` is high and `rd_ready` is low, the request and its address are held.
- R3: Writing the global table register sets the table base from bits 47:16 and the table limit from bits 15:0.
- R4: If index*8+7 is greater than the selected table's limit, the load ends with an `ld_fault` pulse. No read is issued and neither cache changes.
- R5: A local-table selector load does the following:
  - it fetches its descriptor from the global table;
  - it puts that descriptor's base and expanded limit into the local cache;
  - it ends with a fault if its own table bit is 1.
- R6: Descriptor layout.
  - Low word: bits 15:0 are limit 15:0 and bits 31:16 are base 15:0.
  - High word: bits 7:0 are base 23:16, bits 15:8 are the access byte, bits 19:16 are limit 19:16, bit 23 is the granularity flag, and bits 31:24 are base 31:24.
- R7: When the granularity flag is set, the expanded limit is {limit, 12'hFFF}. When it is clear, the expanded limit is the 20-bit limit zero-extended.
- R8: `lin_addr` equals the cached segment base plus `eff_addr`, modulo 2^32.
- R9: `lim_fault` is high when `eff_addr` is greater than the expanded limit. It is also high when the segment is null or has never been loaded, which includes the state after reset.
- R10: Null selectors.
  - A global selector with index 0 completes with no memory read and marks its target null.
  - A local segment load made while the local table is null ends with `ld_fault`.
- R11: `busy` goes high on the cycle after a load is accepted and stays high until the cache has been written. Loads and global-register writes presented while `busy` is high are ignored.
- R12: A successful load, including a null load, gives a one-cycle `ld_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gtr_wr | input | 1 | Write strobe for the global table register |
| gtr_data | input | 48 | Global table register value: base in bits 47:16, limit in bits 15:0 |
| ldt_wr | input | 1 | Load the local-table selector (takes priority over `seg_wr`) |
| ldt_sel | input | 16 | Local-table selector |
| seg_wr | input | 1 | Load the segment selector |
| seg_sel | input | 16 | Segment selector |
| busy | output | 1 | A load is in progress |
| ld_done | output | 1 | Load completed (one-cycle pulse) |
| ld_fault | output | 1 | Load rejected by the table bound check (one-cycle pulse) |
| rd_valid | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read byte address |
| rd_ready | input | 1 | Read accepted; `rd_data` is valid in the same cycle |
| rd_data | input | 32 | Memory read data |
| eff_addr | input | 32 | Effective address to translate |
| lin_addr | output | 32 | Linear address |
| lim_fault | output | 1 | Segment limit violation or null segment |

## Verification
The testbench loads global segments of several kinds and compares the resulting translations against values computed in the bench:

- A byte-granular segment is tested at its limit and one byte above it, which shows that the compare is inclusive.
- A page-granular segment shows that the low 12 bits of the limit are filled with ones.
- A segment with a high base shows that the add wraps at 2^32.
- A local segment with a limit above 16 bits shows that limit bits 19:16 are taken from the high word.
- The local path is exercised with the local index at both the largest value inside the table bound and the smallest value outside it, which separates a correct local-table limit from a wrong one.

Null, faulting and busy-overlapped loads are each followed by an unchanged translation and by a check of how many reads were made. A stalled-ready run shows that the request is held until it is accepted.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RD_LO,
        ST_RD_HI,
        ST_COMMIT,
        ST_FAULT
    } fetch_st_t;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] elim;
        logic        valid;
    } seg_cache_t;
endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode #(
    parameter int AW  = 32,
    parameter int DLW = 20,
    parameter int GSH = 12
) (
    input  logic [AW-1:0] lo_word,
    input  logic [AW-1:0] hi_word,
    output logic [AW-1:0] base,
    output logic [AW-1:0] elim
);
    localparam int PAD = AW - DLW;

    logic [DLW-1:0] lim_raw;
    logic           gran;

    always_comb begin
        lim_raw = {hi_word[19:16], lo_word[15:0]};
        gran    = hi_word[23];
        base    = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
    end

    generate
        if (PAD == GSH) begin : g_full
            assign elim = gran ? {lim_raw, {GSH{1'b1}}} : {{PAD{1'b0}}, lim_raw};
        end else begin : g_clip
            assign elim = gran ? {AW{1'b1}} : {{PAD{1'b0}}, lim_raw};
        end
    endgenerate
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
    import seg_pkg::*;
#(
    parameter int AW = 32
) (
    input  seg_cache_t    cache,
    input  logic [AW-1:0] ea,
    output logic [AW-1:0] lin,
    output logic          fault
);
    always_comb begin
        lin   = cache.base + ea;
        fault = !cache.valid || (ea > cache.elim);
    end
endmodule

// File: rtl/seg_fetch_ctrl.sv
module seg_fetch_ctrl
    import seg_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SW  = 16,
    parameter int GLW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           start_ldt,
    input  logic [SW-1:0]  sel_in,
    input  logic [AW-1:0]  gdt_base,
    input  logic [GLW-1:0] gdt_lim,
    input  logic [AW-1:0]  ldt_base,
    input  logic [AW-1:0]  ldt_elim,
    input  logic           ldt_valid,
    output logic           rd_valid,
    output logic [AW-1:0]  rd_addr,
    input  logic           rd_ready,
    input  logic [AW-1:0]  rd_data,
    output logic           busy,
    output logic           done,
    output logic           fault,
    output logic           op_ldt,
    output logic           op_null,
    output logic [AW-1:0]  lo_word,
    output logic [AW-1:0]  hi_word
);
    localparam int IW    = SW - 3;
    localparam int EXT   = AW - SW;
    localparam int GEXT  = AW - GLW;
    localparam int DBYTE = 8;

    fetch_st_t      st, st_nx;
    logic [SW-1:2]  sel_q;
    logic [AW-1:0]  desc_addr;
    logic [IW-1:0]  idx;
    logic           ti;
    logic [AW-1:0]  span, offs, tbl_base, tbl_lim;
    logic           is_null, bad;

    always_comb begin
        idx      = sel_q[SW-1:3];
        ti       = sel_q[2];
        span     = {{EXT{1'b0}}, idx, 3'b111};
        offs     = {{EXT{1'b0}}, idx, 3'b000};
        tbl_base = ti ? ldt_base : gdt_base;
        tbl_lim  = ti ? ldt_elim : {{GEXT{1'b0}}, gdt_lim};
        is_null  = !ti && (idx == '0);
        bad      = (op_ldt && ti) || (ti && !ldt_valid) || (span > tbl_lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (start) st_nx = ST_CHECK;
            ST_CHECK:  st_nx = is_null ? ST_COMMIT : (bad ? ST_FAULT : ST_RD_LO);
            ST_RD_LO:  if (rd_ready) st_nx = ST_RD_HI;
            ST_RD_HI:  if (rd_ready) st_nx = ST_COMMIT;
            ST_COMMIT: st_nx = ST_IDLE;
            ST_FAULT:  st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_addr  = desc_addr;
        busy     = 1'b1;
        done     = 1'b0;
        fault    = 1'b0;
        unique case (st)
            ST_IDLE:   busy = 1'b0;
            ST_CHECK:  ;
            ST_RD_LO:  rd_valid = 1'b1;
            ST_RD_HI: begin
                rd_valid = 1'b1;
                rd_addr  = desc_addr + AW'(DBYTE / 2);
            end
            ST_COMMIT: done  = 1'b1;
            ST_FAULT:  fault = 1'b1;
            default:   busy  = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= '0;
            op_ldt    <= 1'b0;
            op_null   <= 1'b0;
            desc_addr <= '0;
            lo_word   <= '0;
            hi_word   <= '0;
        end else begin
            if (st == ST_IDLE && start) begin
                sel_q  <= sel_in[SW-1:2];
                op_ldt <= start_ldt;
            end
            if (st == ST_CHECK) begin
                op_null   <= is_null;
                desc_addr <= tbl_base + offs;
            end
            if (st == ST_RD_LO && rd_ready) lo_word <= rd_data;
            if (st == ST_RD_HI && rd_ready) hi_word <= rd_data;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));  // R2
    AST_HI_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RD_LO && rd_ready) |=> rd_valid && (rd_addr == $past(rd_addr) + AW'(4)));  // R2
    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);  // R11
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SW  = 16,
    parameter int GLW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gtr_wr,
    input  logic [AW+GLW-1:0]   gtr_data,
    input  logic                ldt_wr,
    input  logic [SW-1:0]       ldt_sel,
    input  logic                seg_wr,
    input  logic [SW-1:0]       seg_sel,
    output logic                busy,
    output logic                ld_done,
    output logic                ld_fault,
    output logic                rd_valid,
    output logic [AW-1:0]       rd_addr,
    input  logic                rd_ready,
    input  logic [AW-1:0]       rd_data,
    input  logic [AW-1:0]       eff_addr,
    output logic [AW-1:0]       lin_addr,
    output logic                lim_fault
);
    localparam int GTR_W = AW + GLW;

    logic [AW-1:0]  gdt_base;
    logic [GLW-1:0] gdt_lim;
    seg_cache_t     ldt_q, seg_q, new_ent;
    logic           start, op_ldt, op_null;
    logic [SW-1:0]  sel_in;
    logic [AW-1:0]  lo_word, hi_word, d_base, d_elim;

    always_comb begin
        start  = (ldt_wr || seg_wr) && !busy;
        sel_in = ldt_wr ? ldt_sel : seg_sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gdt_base <= '0;
            gdt_lim  <= '0;
        end else if (gtr_wr && !busy) begin
            gdt_base <= gtr_data[GTR_W-1:GLW];
            gdt_lim  <= gtr_data[GLW-1:0];
        end
    end

    seg_fetch_ctrl #(.AW(AW), .SW(SW), .GLW(GLW)) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_ldt(ldt_wr), .sel_in(sel_in),
        .gdt_base(gdt_base), .gdt_lim(gdt_lim),
        .ldt_base(ldt_q.base), .ldt_elim(ldt_q.elim), .ldt_valid(ldt_q.valid),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .busy(busy), .done(ld_done), .fault(ld_fault),
        .op_ldt(op_ldt), .op_null(op_null),
        .lo_word(lo_word), .hi_word(hi_word)
    );

    seg_desc_decode #(.AW(AW)) u_dec (
        .lo_word(lo_word), .hi_word(hi_word),
        .base(d_base), .elim(d_elim)
    );

    always_comb begin
        new_ent.base  = op_null ? '0 : d_base;
        new_ent.elim  = op_null ? '0 : d_elim;
        new_ent.valid = !op_null;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldt_q <= '0;
            seg_q <= '0;
        end else if (ld_done) begin
            if (op_ldt) ldt_q <= new_ent;
            else        seg_q <= new_ent;
        end
    end

    seg_limit_check #(.AW(AW)) u_chk (
        .cache(seg_q), .ea(eff_addr),
        .lin(lin_addr), .fault(lim_fault)
    );

    AST_FAULT_KEEPS_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fault |=> $stable(seg_q) && $stable(ldt_q));  // R4
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |=> !busy);  // R11
endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gtr_wr = 1'b0;
    logic [47:0] gtr_data = '0;
    logic        ldt_wr = 1'b0, seg_wr = 1'b0;
    logic [15:0] ldt_sel = '0, seg_sel = '0;
    logic        busy, ld_done, ld_fault, rd_valid, lim_fault;
    logic [31:0] rd_addr, rd_data, lin_addr;
    logic [31:0] eff_addr = '0;
    logic        stall = 1'b0, ph = 1'b0;
    logic        rd_ready;
    logic [31:0] mem [0:1023];
    int          total = 0, bad = 0;
    int          n_rd = 0;
    logic [31:0] alog [0:3];
    bit          saw_done = 0, saw_fault = 0;

    always #2 clk = ~clk;
    always @(negedge clk) ph <= ~ph;
    assign rd_ready = stall ? ph : 1'b1;
    assign rd_data  = mem[rd_addr[11:2]];

    seg_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .gtr_wr(gtr_wr), .gtr_data(gtr_data),
        .ldt_wr(ldt_wr), .ldt_sel(ldt_sel), .seg_wr(seg_wr), .seg_sel(seg_sel),
        .busy(busy), .ld_done(ld_done), .ld_fault(ld_fault),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .eff_addr(eff_addr), .lin_addr(lin_addr), .lim_fault(lim_fault)
    );

    always @(posedge clk) begin
        if (rd_valid && rd_ready) begin
            if (n_rd < 4) alog[n_rd] <= rd_addr;
            n_rd <= n_rd + 1;
        end
        if (ld_done)  saw_done  <= 1'b1;
        if (ld_fault) saw_fault <= 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] b,
                            input logic [19:0] l, input logic g);
        mem[a[11:2]]     = {b[15:0], l[15:0]};
        mem[a[11:2] + 1] = {b[31:24], g, 3'b000, l[19:16], 8'h92, b[23:16]};
    endtask

    task automatic set_gtr(input logic [31:0] b, input logic [15:0] l);
        @(negedge clk); gtr_wr = 1'b1; gtr_data = {b, l};
        @(negedge clk); gtr_wr = 1'b0;
    endtask

    task automatic do_load(input bit is_ldt, input logic [15:0] s);
        @(negedge clk);
        saw_done = 0; saw_fault = 0; n_rd = 0;
        if (is_ldt) begin ldt_wr = 1'b1; ldt_sel = s; end
        else        begin seg_wr = 1'b1; seg_sel = s; end
        @(negedge clk); ldt_wr = 1'b0; seg_wr = 1'b0;
        for (int i = 0; i < 60 && busy; i++) @(negedge clk);
    endtask

    task automatic xl(input string req, input logic [31:0] ea,
                      input logic [31:0] exp_lin, input logic exp_f);
        eff_addr = ea; #1;
        if (!exp_f) chk(req, lin_addr, exp_lin);
        chk(req, {31'b0, lim_fault}, {31'b0, exp_f});
    endtask

    task automatic t_reset;
        chk("R9 reset busy", {31'b0, busy}, 32'd0);
        chk("R9 reset rd_valid", {31'b0, rd_valid}, 32'd0);
        xl("R9 reset no segment", 32'h0, 32'h0, 1'b1);
    endtask

    task automatic t_global;
        do_load(0, 16'h0010);
        chk("R2 reads", n_rd, 2);
        chk("R2 lo addr", alog[0], 32'h210);
        chk("R2 hi addr", alog[1], 32'h214);
        chk("R12 done", {31'b0, saw_done}, 32'd1);
        xl("R8 base+ea", 32'h10, 32'h110, 1'b0);
        xl("R9 at limit", 32'hFFF, 32'h10FF, 1'b0);
        xl("R9 over limit", 32'h1000, 32'h0, 1'b1);
        do_load(0, 16'h0013);
        xl("R1 rpl ignored", 32'h10, 32'h110, 1'b0);
    endtask

    task automatic t_gran;
        do_load(0, 16'h0018);
        xl("R7 gran top", 32'h2FFF, 32'h0010_2FFF, 1'b0);
        xl("R7 gran over", 32'h3000, 32'h0, 1'b1);
        do_load(0, 16'h00F8);
        xl("R8 wrap", 32'h20, 32'h10, 1'b0);
    endtask

    task automatic t_bound;
        do_load(0, 16'h0010);
        do_load(0, 16'h0100);
        chk("R4 fault", {31'b0, saw_fault}, 32'd1);
        chk("R4 no reads", n_rd, 0);
        xl("R4 cache kept", 32'h10, 32'h110, 1'b0);
    endtask

    task automatic t_local;
        do_load(1, 16'h0038);
        chk("R5 ldt reads", n_rd, 2);
        chk("R5 ldt desc addr", alog[0], 32'h238);
        do_load(0, 16'h0027);
        chk("R5 local desc addr", alog[0], 32'h420);
        chk("R2 local hi addr", alog[1], 32'h424);
        xl("R6 local top nibble", 32'h12345, 32'h0056_2345, 1'b0);
        xl("R6 local over", 32'h12346, 32'h0, 1'b1);
        do_load(0, 16'h003C);
        chk("R4 local edge ok", {31'b0, saw_done}, 32'd1);
        xl("R4 local edge xl", 32'h4, 32'h7004, 1'b0);
        do_load(0, 16'h0044);
        chk("R4 local over", {31'b0, saw_fault}, 32'd1);
        xl("R4 local cache kept", 32'h4, 32'h7004, 1'b0);
        do_load(1, 16'h003C);
        chk("R5 ldt ti set fault", {31'b0, saw_fault}, 32'd1);
    endtask

    task automatic t_null;
        do_load(0, 16'h0003);
        chk("R10 null no reads", n_rd, 0);
        chk("R12 null done", {31'b0, saw_done}, 32'd1);
        xl("R10 null faults", 32'h0, 32'h0, 1'b1);
        do_load(1, 16'h0000);
        chk("R10 ldt null done", {31'b0, saw_done}, 32'd1);
        do_load(0, 16'h0027);
        chk("R10 local after null", {31'b0, saw_fault}, 32'd1);
    endtask

    task automatic t_busy;
        @(negedge clk);
        saw_done = 0; n_rd = 0;
        seg_wr = 1'b1; seg_sel = 16'h0018;
        @(negedge clk); seg_sel = 16'h0010; gtr_wr = 1'b1; gtr_data = 48'h0;
        @(negedge clk); seg_wr = 1'b0; gtr_wr = 1'b0;
        for (int i = 0; i < 60 && busy; i++) @(negedge clk);
        chk("R11 one fetch", n_rd, 2);
        xl("R11 first load wins", 32'h2FFF, 32'h0010_2FFF, 1'b0);
        do_load(0, 16'h0010);
        xl("R11 gtr write ignored", 32'h10, 32'h110, 1'b0);
    endtask

    task automatic t_stall;
        stall = 1'b1;
        do_load(0, 16'h0018);
        do_load(0, 16'h0010);
        stall = 1'b0;
        chk("R2 stall reads", n_rd, 2);
        chk("R2 stall hi", alog[1], 32'h214);
        xl("R2 stall result", 32'h20, 32'h120, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        put_desc(32'h210, 32'h0000_0100, 20'h00FFF, 1'b0);
        put_desc(32'h218, 32'h0010_0000, 20'h00002, 1'b1);
        put_desc(32'h2F8, 32'hFFFF_FFF0, 20'hFFFFF, 1'b1);
        put_desc(32'h238, 32'h0000_0400, 20'h0003F, 1'b0);
        put_desc(32'h420, 32'h0055_0000, 20'h12345, 1'b0);
        put_desc(32'h438, 32'h0000_7000, 20'h00010, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        set_gtr(32'h0000_0200, 16'h00FF);  // R3
        t_global();
        t_gran();
        t_bound();
        t_local();
        t_null();
        t_busy();
        t_stall();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule